// File: doc/BRIEF.md
# Seven-Slot Flat-Panel Link Serializer

This block turns a parallel RGB pixel stream into the bit stream for a low-voltage differential flat-panel link. It runs on the fast slot clock, seven times the pixel rate. Every seven slot-clock cycles it captures one pixel and its three control flags: data enable, horizontal sync and vertical sync. It then places the pixel bits on three or four data lanes, one slot at a time.

A 16-bit format code selects the bit layout. The choices are an 18-bit map on three lanes, a 24-bit map on four lanes that extends the 18-bit one, and a second 24-bit map that keeps the same slot pattern but moves the colour MSBs onto the first three lanes. A clock-lane output gives the seven-slot pixel-clock shape. Per-lane enables tell the pad logic which lanes carry traffic. The internal slot counter starts at slot 0 on reset, so the pixel clock and the bit selection stay locked together.

Top module: `lvds_slot_serializer`

## Requirements
- R1: While `rst` is high, and on the edge that samples it, `laneData`, `clkLane` and `laneEn` are all 0. The first clock edge after `rst` falls captures a pixel as slot 0.
- R2: Each pixel takes exactly seven slot-clock cycles, slots 0 to 6. `clkLane` shows 1,1,0,0,0,1,1 over those slots and then repeats.
- R3: The pixel, control flags and format code are sampled only on the edge that starts slot 0. Changes on those inputs during slots 1 to 6 do not affect the pixel being sent.
- R4: Code 0x1010 selects the 18-bit map and code 0x1011 selects the 24-bit standard map. For slots 0..6, lane 0 carries g0,r5,r4,r3,r2,r1,r0 and lane 1 carries b1,b0,g5,g4,g3,g2,g1.
- R5: In both standard maps, lane 2 carries DE, VSYNC, HSYNC in slots 0,1,2 and then b5,b4,b3,b2.
- R6: In the 24-bit standard map, lane 3 carries for slots 0..6: a reserved 0, then b7,b6,g7,g6,r7,r6.
- R7: Code 0x1012 selects the alternate 24-bit map. For slots 0..6, lane 0 carries g2,r7,r6,r5,r4,r3,r2 and lane 1 carries b3,b2,g7,g6,g5,g4,g3.
- R8: In the alternate 24-bit map, lane 2 carries DE,VSYNC,HSYNC then b7,b6,b5,b4. Lane 3 carries a reserved 0, then b1,b0,g1,g0,r1,r0.
- R9: In 18-bit mode lane 3 stays 0 and `laneEn` is 4'b0111. Both 24-bit modes give `laneEn` = 4'b1111. Bit i of `laneEn` and `laneData` belongs to lane i.
- R10: Any other format code holds all of `laneData` at 0 and `laneEn` at 0 for that pixel. `clkLane` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, seven cycles per pixel |
| rst | input | 1 | Synchronous reset, active high |
| fmtCode | input | 16 | Bit-layout select code |
| pixR | input | 8 | Red component |
| pixG | input | 8 | Green component |
| pixB | input | 8 | Blue component |
| pixDe | input | 1 | Data enable flag |
| pixHs | input | 1 | Horizontal sync flag |
| pixVs | input | 1 | Vertical sync flag |
| laneData | output | 4 | Serial bit of each data lane for the current slot |
| clkLane | output | 1 | Clock-lane pattern bit |
| laneEn | output | 4 | Per-lane active flags |

## Verification
The inputs are sampled on a capture edge, and the slot-0 bits appear one register later, just after that same edge. Slot s then appears just after the s-th following edge, and the next capture falls on the seventh edge. The bench drives each pixel before a capture edge and checks every lane, the clock lane and the enables at the falling edge of each of the next seven cycles. Right after the slot-0 sample it drives unrelated values onto the inputs, so a design that re-samples mid-pixel shows a mismatch in slots 1 to 6. Reset is asserted mid-pixel and released on a falling edge, so the first following rising edge must be a capture.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  localparam int SLOT_N  = 7;
  localparam int SLOT_W  = $clog2(SLOT_N);
  localparam int COLOR_W = 8;
  localparam int LANE_N  = 4;
  localparam int CODE_W  = 16;
  localparam int ROT     = 2;   // alternate map moves the colour bits by this amount

  typedef enum logic [1:0] {
    FMT_OFF,
    FMT_STD18,
    FMT_STD24,
    FMT_ALT24
  } fmt_e;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               de;
    logic               hs;
    logic               vs;
  } pix_t;

  typedef struct packed {
    logic              capture;
    logic [SLOT_W-1:0] slot;
    logic              clkBit;
  } strobe_t;

  // The alternate layout equals the standard layout applied to colours whose
  // upper six bits have been moved down and whose two LSBs have gone to the top.
  function automatic logic [COLOR_W-1:0] rotColor(input logic [COLOR_W-1:0] c);
    return {c[ROT-1:0], c[COLOR_W-1:ROT]};
  endfunction

  function automatic pix_t altReorder(input pix_t p);
    pix_t q;
    q    = p;
    q.r  = rotColor(p.r);
    q.g  = rotColor(p.g);
    q.b  = rotColor(p.b);
    return q;
  endfunction

  // Standard scatter: each lane is a 7-bit word with slot 0 at the MSB.
  function automatic logic [LANE_N-1:0] scatter(input pix_t p,
                                                input logic [SLOT_W-1:0] s);
    logic [SLOT_N-1:0] w0, w1, w2, w3;
    logic [LANE_N-1:0] o;
    int idx;
    w0  = {p.g[0], p.r[5:0]};
    w1  = {p.b[1:0], p.g[5:1]};
    w2  = {p.de, p.vs, p.hs, p.b[5:2]};
    w3  = {1'b0, p.b[7:6], p.g[7:6], p.r[7:6]};
    idx = SLOT_N - 1 - int'(s);
    o   = '0;
    if (idx >= 0 && idx < SLOT_N) begin
      o = {w3[idx], w2[idx], w1[idx], w0[idx]};
    end
    return o;
  endfunction

endpackage

// File: rtl/lvds_slot_ctrl.sv
module lvds_slot_ctrl
  import lvds_ser_pkg::*;
#(
  parameter int CLK_HIGH_HEAD = 2,   // clock lane high for slots below this
  parameter int CLK_HIGH_TAIL = 5    // and for slots from this one on
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobe
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N - 1);
  localparam logic [SLOT_W-1:0] HEAD_LIM  = SLOT_W'(CLK_HIGH_HEAD);
  localparam logic [SLOT_W-1:0] TAIL_LIM  = SLOT_W'(CLK_HIGH_TAIL);

  logic [SLOT_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
    end else if (slotCnt == LAST_SLOT) begin
      slotCnt <= '0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.capture = (slotCnt == '0);
    strobe.slot    = slotCnt;
    strobe.clkBit  = (slotCnt < HEAD_LIM) || (slotCnt >= TAIL_LIM);
  end

endmodule

// File: rtl/lvds_slot_datapath.sv
module lvds_slot_datapath
  import lvds_ser_pkg::*;
#(
  parameter logic [CODE_W-1:0] CODE_STD18 = 16'h1010,
  parameter logic [CODE_W-1:0] CODE_STD24 = 16'h1011,
  parameter logic [CODE_W-1:0] CODE_ALT24 = 16'h1012
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [CODE_W-1:0] fmtCode,
  input  pix_t              pixIn,
  output logic [LANE_N-1:0] laneData,
  output logic              clkLane,
  output logic [LANE_N-1:0] laneEn
);

  fmt_e              liveFmt, holdFmt, srcFmt;
  pix_t              holdPix, srcPix, mappedPix;
  logic [LANE_N-1:0] slotBits, laneMask, gatedBits;

  always_comb begin
    unique case (fmtCode)
      CODE_STD18: liveFmt = FMT_STD18;
      CODE_STD24: liveFmt = FMT_STD24;
      CODE_ALT24: liveFmt = FMT_ALT24;
      default:    liveFmt = FMT_OFF;
    endcase
  end

  // Holding register: loaded once per pixel at the start of slot 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      holdPix <= '0;
      holdFmt <= FMT_OFF;
    end else if (strobe.capture) begin
      holdPix <= pixIn;
      holdFmt <= liveFmt;
    end
  end

  // Slot 0 is built from the values being captured on the same edge.
  assign srcPix = strobe.capture ? pixIn   : holdPix;
  assign srcFmt = strobe.capture ? liveFmt : holdFmt;

  assign mappedPix = (srcFmt == FMT_ALT24) ? altReorder(srcPix) : srcPix;
  assign slotBits  = scatter(mappedPix, strobe.slot);

  always_comb begin
    unique case (srcFmt)
      FMT_STD18:            laneMask = {1'b0, {(LANE_N-1){1'b1}}};
      FMT_STD24, FMT_ALT24: laneMask = '1;
      default:              laneMask = '0;
    endcase
  end

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    assign gatedBits[i] = slotBits[i] & laneMask[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      laneData <= '0;
      clkLane  <= 1'b0;
      laneEn   <= '0;
    end else begin
      laneData <= gatedBits;
      clkLane  <= strobe.clkBit;
      if (strobe.capture) begin
        laneEn <= laneMask;
      end
    end
  end

endmodule

// File: rtl/lvds_slot_serializer.sv
module lvds_slot_serializer
  import lvds_ser_pkg::*;
#(
  parameter logic [15:0] CODE_STD18 = 16'h1010,
  parameter logic [15:0] CODE_STD24 = 16'h1011,
  parameter logic [15:0] CODE_ALT24 = 16'h1012
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] fmtCode,
  input  logic [7:0]  pixR,
  input  logic [7:0]  pixG,
  input  logic [7:0]  pixB,
  input  logic        pixDe,
  input  logic        pixHs,
  input  logic        pixVs,
  output logic [3:0]  laneData,
  output logic        clkLane,
  output logic [3:0]  laneEn
);

  strobe_t strobe;
  pix_t    pixIn;

  assign pixIn = '{r: pixR, g: pixG, b: pixB, de: pixDe, hs: pixHs, vs: pixVs};

  lvds_slot_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  lvds_slot_datapath #(
    .CODE_STD18 (CODE_STD18),
    .CODE_STD24 (CODE_STD24),
    .CODE_ALT24 (CODE_ALT24)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .fmtCode  (fmtCode),
    .pixIn    (pixIn),
    .laneData (laneData),
    .clkLane  (clkLane),
    .laneEn   (laneEn)
  );

endmodule

// File: rtl/lvds_slot_serializer_chk.sv
module lvds_slot_serializer_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] laneData,
  input logic       clkLane,
  input logic [3:0] laneEn
);

  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (laneData == 4'd0 && !clkLane && laneEn == 4'd0)); // R1

  AST_CLK_HIGH_PAIR: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(clkLane) |=> clkLane); // R2

  AST_CLK_LOW_RUN: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(clkLane) |=> !clkLane ##1 !clkLane); // R2

  AST_EN_SHAPE: assert property (@(posedge clk) disable iff (rst || !armed)
    (laneEn == 4'b0000 || laneEn == 4'b0111 || laneEn == 4'b1111)); // R9

  AST_NARROW_LANE3_LOW: assert property (@(posedge clk) disable iff (rst || !armed)
    (laneEn == 4'b0111) |-> !laneData[3]); // R9

  AST_IDLE_LANES_LOW: assert property (@(posedge clk) disable iff (rst || !armed)
    (laneEn == 4'b0000) |-> (laneData == 4'd0)); // R10

endmodule

bind lvds_slot_serializer lvds_slot_serializer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .laneData (laneData),
  .clkLane  (clkLane),
  .laneEn   (laneEn)
);

// File: tb/lvds_slot_serializer_tb.sv
`timescale 1ns/1ps
module lvds_slot_serializer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fmtCode = 16'h0;
  logic [7:0]  pixR = '0, pixG = '0, pixB = '0;
  logic        pixDe = 1'b0, pixHs = 1'b0, pixVs = 1'b0;
  logic [3:0]  laneData, laneEn;
  logic        clkLane;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lvds_slot_serializer u_dut (
    .clk(clk), .rst(rst), .fmtCode(fmtCode),
    .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .pixDe(pixDe), .pixHs(pixHs), .pixVs(pixVs),
    .laneData(laneData), .clkLane(clkLane), .laneEn(laneEn)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp,
                     input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  // Reference lane words straight from the requirement tables, slot 0 at MSB.
  function automatic logic [3:0] expLanes(input logic [15:0] code,
      input logic [7:0] r, g, b, input logic de, hs, vs, input int s);
    logic [6:0] w0, w1, w2, w3;
    w0 = '0; w1 = '0; w2 = '0; w3 = '0;
    case (code)
      16'h1010, 16'h1011: begin   // R4 R5 R6
        w0 = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
        w1 = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
        w2 = {de, vs, hs, b[5], b[4], b[3], b[2]};
        if (code == 16'h1011) w3 = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
      end
      16'h1012: begin             // R7 R8
        w0 = {g[2], r[7], r[6], r[5], r[4], r[3], r[2]};
        w1 = {b[3], b[2], g[7], g[6], g[5], g[4], g[3]};
        w2 = {de, vs, hs, b[7], b[6], b[5], b[4]};
        w3 = {1'b0, b[1], b[0], g[1], g[0], r[1], r[0]};
      end
      default: ;                  // R10
    endcase
    return {w3[6-s], w2[6-s], w1[6-s], w0[6-s]};
  endfunction

  function automatic logic [3:0] expEn(input logic [15:0] code);
    case (code)
      16'h1010:           return 4'b0111;
      16'h1011, 16'h1012: return 4'b1111;
      default:            return 4'b0000;
    endcase
  endfunction

  // Called at a falling edge just before a capture edge. Returns at the
  // falling edge just before the next capture edge.
  task automatic runPixel(input logic [15:0] code, input logic [7:0] r, g, b,
      input logic de, hs, vs, input string tLo, tL2, tL3, tEn);
    logic [3:0] e;
    fmtCode = code; pixR = r; pixG = g; pixB = b;
    pixDe = de; pixHs = hs; pixVs = vs;
    @(posedge clk);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      e = expLanes(code, r, g, b, de, hs, vs, s);
      chk(tLo, {2'b0, laneData[1:0]}, {2'b0, e[1:0]}, $sformatf("lanes0-1 slot%0d", s));
      chk(tL2, {3'b0, laneData[2]}, {3'b0, e[2]}, $sformatf("lane2 slot%0d", s));
      chk(tL3, {3'b0, laneData[3]}, {3'b0, e[3]}, $sformatf("lane3 slot%0d", s));
      chk("R2", {3'b0, clkLane}, {3'b0, (s < 2 || s > 4)}, $sformatf("clk slot%0d", s));
      chk(tEn, laneEn, expEn(code), $sformatf("laneEn slot%0d", s));
      if (s == 0) begin
        // R3: disturb the inputs mid-pixel; the current pixel must not change
        fmtCode = ~code; pixR = ~r; pixG = ~g; pixB = ~b;
        pixDe = ~de; pixHs = ~hs; pixVs = ~vs;
      end
    end
  endtask

  task automatic testResetIdle();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", laneData, 4'd0, "lanes in reset");
      chk("R1", {3'b0, clkLane}, 4'd0, "clk in reset");
      chk("R1", laneEn, 4'd0, "enables in reset");
    end
    rst = 1'b0;
  endtask

  task automatic testStd18();
    runPixel(16'h1010, 8'hA5, 8'h3C, 8'h96, 1'b1, 1'b0, 1'b1, "R4", "R5", "R9", "R9");
    runPixel(16'h1010, 8'h5A, 8'hC3, 8'h69, 1'b0, 1'b1, 1'b0, "R4", "R5", "R9", "R9");
  endtask

  task automatic testStd24();
    runPixel(16'h1011, 8'hC1, 8'h7E, 8'hB2, 1'b1, 1'b1, 1'b0, "R4", "R5", "R6", "R9");
    runPixel(16'h1011, 8'h3E, 8'h81, 8'h4D, 1'b0, 1'b0, 1'b1, "R4", "R5", "R6", "R9");
  endtask

  task automatic testAlt24();
    runPixel(16'h1012, 8'hC1, 8'h7E, 8'hB2, 1'b1, 1'b0, 1'b0, "R7", "R8", "R8", "R9");
    runPixel(16'h1012, 8'h1F, 8'hE4, 8'h0B, 1'b0, 1'b1, 1'b1, "R7", "R8", "R8", "R9");
  endtask

  task automatic testBadCode();
    runPixel(16'h0000, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, "R10", "R10", "R10", "R10");
    runPixel(16'h1013, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, "R10", "R10", "R10", "R10");
  endtask

  task automatic testHold();
    // R3: same disturbance, checked on a pixel with every bit distinct from its inverse
    runPixel(16'h1011, 8'h0F, 8'hF0, 8'h33, 1'b1, 1'b0, 1'b1, "R3", "R3", "R3", "R3");
  endtask

  task automatic testMidReset();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", laneData, 4'd0, "lanes after mid-pixel reset");
    chk("R1", laneEn, 4'd0, "enables after mid-pixel reset");
    @(negedge clk);
    rst = 1'b0;
    runPixel(16'h1012, 8'h96, 8'h5A, 8'hC3, 1'b1, 1'b1, 1'b0, "R1", "R1", "R1", "R1");
  endtask

  initial begin
    testResetIdle();
    testStd18();
    testStd24();
    testAlt24();
    testBadCode();
    testHold();
    testStd18();
    testMidReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule